// File: doc/BRIEF.md
# Steered Serial Audio and Register Port

This block is the slave side of a synchronous serial link that exchanges one word per sample frame with a host processor. The host supplies a serial clock and a one-bit-wide frame pulse; one period before the first bit it raises the frame pulse. Each frame then moves one word in on the receive line and one word out on the transmit line at the same time. In the 16-bit mode the first received bit steers the word. A zero marks an audio sample, which goes to the core through a parallel output with a strobe. A one marks a register access to a small file of three 12-bit registers.

A register access returns one reply word. The reply carries the steering bit, the read/write flag, the address and the contents the register held before the access. The reply is sent in place of outbound audio in the frame that follows the access. A frame that carries a register access brings in no audio, so the core sees the previous sample repeated. Register 0 is guarded: a serial write can change it only in the frame straight after the sleep command word, and a software reset bit inside it blocks writes while it is set. An 8-bit mode carries companded audio only, with no steering and no register access.

The serial clock, frame pulse and receive data are treated as slow inputs synchronous to the system clock. Edges are found by comparing each sample against the one taken a cycle earlier.

Top module: `steer_port`

## Requirements
- R1: While rst_n is low, sdo_en, sdo, rx_strobe, rx_audio and all three register outputs are zero.
- R2: In 16-bit linear mode (wide_mode=1, compand=0), a complete frame whose first bit is 0 puts the 16 received bits, MSB first, on rx_audio. rx_strobe pulses for exactly one clock when the frame completes.
- R3: The outbound word is sent MSB first, one bit per serial-clock rising edge, starting at the first rising edge after the frame pulse is seen on a falling edge. In 16-bit linear mode it is the tx_audio value present at that falling edge. sdo_en is high from the first bit until the rising edge after the last bit, and sdo is low whenever sdo_en is low.
- R4: A control word has bit 15 = 1, bit 14 = read-not-write, bits 13:12 = address and bits 11:0 = data. With bit 14 = 0 and address 1 or 2, the data lands in ctl_reg1 or ctl_reg2. The next frame sends the reply {1, rnw, address, value before the access} instead of audio.
- R5: A control word with bit 14 = 1 leaves all registers unchanged, whatever its data field holds. Its reply in the next frame carries the addressed register's contents.
- R6: A frame that carries a control word leaves rx_audio unchanged, but rx_strobe still pulses once.
- R7: A write to address 0 is ignored unless the complete frame just before it was the word 0x8400. The word 0x8400 itself sets bit 10 of ctl_reg0 and leaves the other bits as they were.
- R8: Address 3 is reserved. Writes to it change nothing, and reads of it return zero data.
- R9: In 16-bit companded mode (wide_mode=1, compand=1), rx_audio takes {8'h00, received bits 7:0}. The outbound word is {tx_audio[7:0], 8'h00}.
- R10: In 8-bit mode (wide_mode=0), frames are 8 bits long and every frame is audio, whatever its first bit. rx_audio takes {8'h00, code}, sdo sends tx_audio[7:0] MSB first, and sdo_en covers those 8 bits.
- R11: If a new frame pulse arrives before the current frame has all its bits, the partial frame is discarded. There is no strobe, no register change and no audio update.
- R12: Bit 11 of ctl_reg0 is the software reset. chip_reset high clears it on the next clock. While it is set, writes to registers 1 and 2 are ignored and a write to register 0 changes only bit 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_reset | input | 1 | Hardware reset request; clears the software reset bit |
| wide_mode | input | 1 | 1 = 16-bit steered frames, 0 = 8-bit audio-only frames |
| compand | input | 1 | In 16-bit mode, 1 = audio carried as 8-bit codes |
| sclk | input | 1 | Serial clock from the host |
| ssync | input | 1 | Frame pulse, sampled on serial-clock falling edges |
| sdi | input | 1 | Serial receive data, sampled on falling edges |
| sdo | output | 1 | Serial transmit data, launched on rising edges |
| sdo_en | output | 1 | High while sdo carries a driven bit |
| tx_audio | input | 16 | Outbound audio sample from the core |
| rx_audio | output | 16 | Latest inbound audio sample |
| rx_strobe | output | 1 | One-clock pulse per completed frame |
| ctl_reg0 | output | 12 | Register 0 (bit 11 software reset, bit 10 sleep) |
| ctl_reg1 | output | 12 | Register 1 |
| ctl_reg2 | output | 12 | Register 2 |

## Verification
The link is driven with linear audio words of both polarities and with writes and reads to every address, including the reserved one. Because replies arrive one frame late, the outbound word is checked bit by bit every frame; this separates a stale reply from a fresh audio sample. Guard sequences cover the sleep command followed at once by a register 0 write, the sleep command separated from that write by an audio frame, and the software reset bit set and then cleared by chip_reset. These tell the lock and the reset gating apart from ordinary writes. Companded 16-bit frames, 8-bit frames with the top bit set, and a truncated frame followed by a full one show that the steering bit is honoured only in 16-bit mode and that a partial word leaves no trace.

// File: rtl/steer_port_pkg.sv
// Shared constants and the control-word layout for the steered serial port.
// Assumes the register file holds exactly three 12-bit registers.
package steer_port_pkg;
    localparam int WORD_W    = 16;
    localparam int NARROW_W  = 8;
    localparam int ADDR_W    = 2;
    localparam int DATA_W    = 12;
    localparam int NUM_REGS  = 3;
    localparam int SWRST_BIT = 11;
    localparam int SLEEP_BIT = 10;

    typedef struct packed {
        logic              steer;
        logic              rnw;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } ctrl_word_t;
endpackage

// File: rtl/steer_port_shifter.sv
// Serial framing engine. It finds serial-clock edges in the system clock
// domain, starts a frame when the frame pulse is seen on a falling edge,
// launches outbound bits on rising edges and captures inbound bits on
// falling edges. A frame cut short by a new pulse is dropped.
// Assumes sclk/ssync/sdi are synchronous to clk and change slowly.
module steer_port_shifter #(
    parameter int WORD_W   = 16,
    parameter int NARROW_W = 8,
    localparam int CNT_W   = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic              sclk,
    input  logic              ssync,
    input  logic              sdi,
    input  logic [WORD_W-1:0] tx_word,
    output logic              sdo,
    output logic              sdo_en,
    output logic              frame_start,
    output logic              frame_done,
    output logic [WORD_W-1:0] rx_word
);
    localparam logic [CNT_W-1:0] LEN_WIDE   = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] LEN_NARROW = CNT_W'(NARROW_W);

    logic              sclk_q;
    logic              active;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] rx_sh;
    logic [WORD_W-1:0] tx_sh;
    logic              fall, rise;
    logic [CNT_W-1:0]  frame_len;

    // Edge detection against the previous serial-clock sample.
    always_comb begin
        fall      = sclk_q & ~sclk;
        rise      = ~sclk_q & sclk;
        frame_len = wide_mode ? LEN_WIDE : LEN_NARROW;
    end

    // Frame sequencing, shifting and tri-state control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q      <= 1'b1;
            active      <= 1'b0;
            cnt         <= '0;
            rx_sh       <= '0;
            tx_sh       <= '0;
            rx_word     <= '0;
            sdo         <= 1'b0;
            sdo_en      <= 1'b0;
            frame_start <= 1'b0;
            frame_done  <= 1'b0;
        end else begin
            sclk_q      <= sclk;
            frame_start <= 1'b0;
            frame_done  <= 1'b0;
            if (fall) begin
                if (ssync) begin
                    active      <= 1'b1;
                    cnt         <= '0;
                    rx_sh       <= '0;
                    tx_sh       <= tx_word;
                    frame_start <= 1'b1;
                end else if (active && (cnt < frame_len)) begin
                    rx_sh <= {rx_sh[WORD_W-2:0], sdi};
                    cnt   <= cnt + 1'b1;
                    if (cnt == frame_len - 1'b1) begin
                        frame_done <= 1'b1;
                        rx_word    <= {rx_sh[WORD_W-2:0], sdi};
                    end
                end
            end else if (rise && active) begin
                if (cnt < frame_len) begin
                    sdo    <= tx_sh[WORD_W-1];
                    tx_sh  <= {tx_sh[WORD_W-2:0], 1'b0};
                    sdo_en <= 1'b1;
                end else begin
                    sdo    <= 1'b0;
                    sdo_en <= 1'b0;
                    active <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/steer_port_regs.sv
// Control register file. Register 0 accepts serial writes only in the frame
// right after the sleep command, and its software reset bit gates writes.
// old_value gives the addressed contents before any update in this cycle.
// Assumes req/done are single-cycle pulses per completed frame.
module steer_port_regs #(
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 12,
    parameter int NUM_REGS  = 3,
    parameter int SWRST_BIT = 11,
    parameter int SLEEP_BIT = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       chip_reset,
    input  logic                       done,
    input  logic                       req,
    input  logic                       rnw,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat,
    output logic [DATA_W-1:0]          old_value
);
    localparam logic [DATA_W-1:0] SLEEP_DATA = DATA_W'(1) << SLEEP_BIT;

    logic unlock;
    logic swrst;
    logic wr;
    logic sleep_cmd;

    // Decode the write strobe and the sleep command word.
    always_comb begin
        wr        = req && !rnw;
        sleep_cmd = wr && (addr == '0) && (wdata == SLEEP_DATA);
        swrst     = regs_flat[SWRST_BIT];
        old_value = '0;
        if (int'(addr) < NUM_REGS)
            old_value = regs_flat[int'(addr)*DATA_W +: DATA_W];
    end

    // Unlock window: open for exactly the frame after the sleep command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            unlock <= 1'b0;
        else if (done)
            unlock <= sleep_cmd;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [DATA_W-1:0] q;
        assign regs_flat[g*DATA_W +: DATA_W] = q;
        if (g == 0) begin : g_guarded
            // Guarded register: sleep command, unlocked write, reset clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else begin
                    if (wr && (addr == '0)) begin
                        if (sleep_cmd) begin
                            if (!swrst) q[SLEEP_BIT] <= 1'b1;
                        end else if (unlock) begin
                            if (swrst) q[SWRST_BIT] <= wdata[SWRST_BIT];
                            else       q <= wdata;
                        end
                    end
                    if (chip_reset) q[SWRST_BIT] <= 1'b0;
                end
            end
        end else begin : g_plain
            // Plain register: written unless software reset is active.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (wr && (int'(addr) == g) && !swrst)
                    q <= wdata;
            end
        end
    end
endmodule

// File: rtl/steer_port.sv
// Top of the steered serial port. It routes each completed frame to the
// audio output or to the register file, holds the reply of a register
// access for the next frame, and picks the outbound word for each mode.
// Assumes wide_mode and compand are held stable while frames run.
module steer_port
    import steer_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_reset,
    input  logic              wide_mode,
    input  logic              compand,
    input  logic              sclk,
    input  logic              ssync,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_en,
    input  logic [WORD_W-1:0] tx_audio,
    output logic [WORD_W-1:0] rx_audio,
    output logic              rx_strobe,
    output logic [DATA_W-1:0] ctl_reg0,
    output logic [DATA_W-1:0] ctl_reg1,
    output logic [DATA_W-1:0] ctl_reg2
);
    localparam int PAD_W = WORD_W - NARROW_W;

    logic [WORD_W-1:0]          tx_word;
    logic [WORD_W-1:0]          rx_word;
    logic                       frame_start, frame_done;
    ctrl_word_t                 cw;
    logic                       is_ctrl;
    logic                       pending;
    logic [WORD_W-1:0]          reply;
    logic [DATA_W-1:0]          old_value;
    logic [NUM_REGS*DATA_W-1:0] regs_flat;

    // Outbound word choice and steering decode of the received word.
    always_comb begin
        cw      = ctrl_word_t'(rx_word);
        is_ctrl = wide_mode && cw.steer;
        if (pending && wide_mode)
            tx_word = reply;
        else if (wide_mode && !compand)
            tx_word = tx_audio;
        else
            tx_word = {tx_audio[NARROW_W-1:0], {PAD_W{1'b0}}};
    end

    steer_port_shifter #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_shifter (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
        .sclk(sclk), .ssync(ssync), .sdi(sdi), .tx_word(tx_word),
        .sdo(sdo), .sdo_en(sdo_en), .frame_start(frame_start),
        .frame_done(frame_done), .rx_word(rx_word)
    );

    steer_port_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
        .SWRST_BIT(SWRST_BIT), .SLEEP_BIT(SLEEP_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .chip_reset(chip_reset),
        .done(frame_done), .req(frame_done && is_ctrl), .rnw(cw.rnw),
        .addr(cw.addr), .wdata(cw.data), .regs_flat(regs_flat),
        .old_value(old_value)
    );

    // Audio capture, frame strobe and reply bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_audio  <= '0;
            rx_strobe <= 1'b0;
            pending   <= 1'b0;
            reply     <= '0;
        end else begin
            rx_strobe <= frame_done;
            if (frame_start) pending <= 1'b0;
            if (frame_done) begin
                if (is_ctrl) begin
                    pending <= 1'b1;
                    reply   <= {1'b1, cw.rnw, cw.addr, old_value};
                end else if (wide_mode && !compand) begin
                    rx_audio <= rx_word;
                end else begin
                    rx_audio <= {{PAD_W{1'b0}}, rx_word[NARROW_W-1:0]};
                end
            end
        end
    end

    assign ctl_reg0 = regs_flat[0*DATA_W +: DATA_W];
    assign ctl_reg1 = regs_flat[1*DATA_W +: DATA_W];
    assign ctl_reg2 = regs_flat[2*DATA_W +: DATA_W];
endmodule

// File: rtl/steer_port_chk.sv
// Property checker for the steered serial port, bound to the top module.
// Assumes serial-clock edges are many system clocks apart.
module steer_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        chip_reset,
    input logic        sdo,
    input logic        sdo_en,
    input logic [15:0] rx_audio,
    input logic        rx_strobe,
    input logic [11:0] ctl_reg0,
    input logic [11:0] ctl_reg1,
    input logic [11:0] ctl_reg2
);
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> !rx_strobe); // R2
    AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_en |-> !sdo); // R3
    AST_REG1_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_reg1 != $past(ctl_reg1)) |-> rx_strobe); // R4
    AST_REG2_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_reg2 != $past(ctl_reg2)) |-> rx_strobe); // R4
    AST_AUDIO_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_audio != $past(rx_audio)) |-> rx_strobe); // R6
    AST_REG0_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_reg0 != $past(ctl_reg0)) |-> (rx_strobe || $past(chip_reset))); // R7
    AST_SWRST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        chip_reset |=> !ctl_reg0[11]); // R12
endmodule

bind steer_port steer_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .chip_reset(chip_reset), .sdo(sdo),
    .sdo_en(sdo_en), .rx_audio(rx_audio), .rx_strobe(rx_strobe),
    .ctl_reg0(ctl_reg0), .ctl_reg1(ctl_reg1), .ctl_reg2(ctl_reg2)
);

// File: tb/steer_port_bench.sv
// Bench for the steered serial port with a behavioural reference model.
module steer_port_bench;
    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst_n, chip_reset, wide_mode, compand;
    logic        sclk, ssync, sdi, sdo, sdo_en, rx_strobe;
    logic [15:0] tx_audio, rx_audio;
    logic [11:0] ctl_reg0, ctl_reg1, ctl_reg2;

    int checks = 0;
    int errors = 0;
    int strobes_seen = 0;
    bit cmp_en = 1'b0;
    bit finished = 1'b0;

    // Reference model state
    logic [15:0] m_rx;
    logic [11:0] m_regs [3];
    bit          m_unlock, m_pending;
    logic [15:0] m_reply;
    int          m_strobes;

    always #10 clk = ~clk;

    steer_port u_steer_port (
        .clk(clk), .rst_n(rst_n), .chip_reset(chip_reset),
        .wide_mode(wide_mode), .compand(compand), .sclk(sclk),
        .ssync(ssync), .sdi(sdi), .sdo(sdo), .sdo_en(sdo_en),
        .tx_audio(tx_audio), .rx_audio(rx_audio), .rx_strobe(rx_strobe),
        .ctl_reg0(ctl_reg0), .ctl_reg1(ctl_reg1), .ctl_reg2(ctl_reg2)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rx_strobe) strobes_seen++;
        if (cmp_en) begin
            chk("R2/R6 rx_audio", rx_audio, m_rx);
            chk("R7/R12 ctl_reg0", ctl_reg0, m_regs[0]);
            chk("R4 ctl_reg1", ctl_reg1, m_regs[1]);
            chk("R4 ctl_reg2", ctl_reg2, m_regs[2]);
        end
    end

    function automatic logic [15:0] model_start();
        logic [15:0] w;
        if (m_pending && wide_mode) w = m_reply;
        else if (wide_mode && !compand) w = tx_audio;
        else w = {tx_audio[7:0], 8'h00};
        m_pending = 1'b0;
        return w;
    endfunction

    task automatic model_done(input logic [15:0] word);
        bit rnw, sleep_cmd, swrst;
        int a;
        logic [11:0] d;
        m_strobes++;
        if (wide_mode && word[15]) begin
            rnw = word[14];
            a = int'(word[13:12]);
            d = word[11:0];
            m_reply = {1'b1, rnw, word[13:12], (a < 3) ? m_regs[a] : 12'h000};
            m_pending = 1'b1;
            swrst = m_regs[0][11];
            sleep_cmd = !rnw && a == 0 && d == 12'h400;
            if (!rnw) begin
                if (a == 0) begin
                    if (sleep_cmd) begin
                        if (!swrst) m_regs[0][10] = 1'b1;
                    end else if (m_unlock) begin
                        if (swrst) m_regs[0][11] = d[11];
                        else m_regs[0] = d;
                    end
                end else if (a < 3 && !swrst) begin
                    m_regs[a] = d;
                end
            end
            m_unlock = sleep_cmd;
        end else begin
            m_rx = (wide_mode && !compand) ? word : {8'h00, word[7:0]};
            m_unlock = 1'b0;
        end
    endtask

    // Drive one frame of nbits bits; fewer than the mode length is a short frame.
    task automatic send_frame(input logic [15:0] word, input int nbits, input string tag);
        logic [15:0] exp_out;
        int full;
        full = wide_mode ? 16 : 8;
        @(negedge clk);
        exp_out = model_start();
        ssync = 1'b1;
        sclk = 1'b0;
        repeat (H) @(negedge clk);
        sclk = 1'b1;
        ssync = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            sdi = word[nbits-1-i];
            repeat (2) @(negedge clk);
            chk({tag, " sdo bit"}, {31'd0, sdo}, {31'd0, exp_out[15-i]});
            chk({tag, " sdo_en"}, {31'd0, sdo_en}, 32'd1);
            repeat (H-2) @(negedge clk);
            if (i == nbits-1 && nbits == full) cmp_en = 1'b0;
            sclk = 1'b0;
            repeat (H) @(negedge clk);
            sclk = 1'b1;
        end
        if (nbits == full) begin
            model_done(word);
            repeat (2) @(negedge clk);
            chk("R3 sdo_en off", {31'd0, sdo_en}, 32'd0);
            cmp_en = 1'b1;
        end
    endtask

    task automatic pulse_chip_reset();
        @(negedge clk);
        cmp_en = 1'b0;
        chip_reset = 1'b1;
        @(negedge clk);
        chip_reset = 1'b0;
        m_regs[0][11] = 1'b0;
        @(negedge clk);
        cmp_en = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; chip_reset = 1'b0; wide_mode = 1'b1; compand = 1'b0;
        sclk = 1'b1; ssync = 1'b0; sdi = 1'b0; tx_audio = 16'h0000;
        m_rx = '0; m_regs[0] = '0; m_regs[1] = '0; m_regs[2] = '0;
        m_unlock = 0; m_pending = 0; m_reply = '0; m_strobes = 0;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 sdo_en", {31'd0, sdo_en}, 32'd0);
        chk("R1 sdo", {31'd0, sdo}, 32'd0);
        chk("R1 rx_strobe", {31'd0, rx_strobe}, 32'd0);
        chk("R1 rx_audio", rx_audio, 32'd0);
        chk("R1 regs", {ctl_reg0, ctl_reg1, ctl_reg2}, 32'd0);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // R2 R3 linear audio both ways
        tx_audio = 16'hA5C3; send_frame(16'h1234, 16, "R2 R3");
        tx_audio = 16'h8001; send_frame(16'h7FFF, 16, "R2 R3");
        // R4 write reg1; R6 audio held
        tx_audio = 16'h1111; send_frame(16'h9ABC, 16, "R4 R6");
        // R5 read reg1 with junk data; reply of write goes out now
        send_frame(16'hDFFF, 16, "R4 R5");
        tx_audio = 16'h2222; send_frame(16'h0555, 16, "R5 reply");
        // R4 write reg2
        send_frame(16'hA7E1, 16, "R4");
        send_frame(16'h0001, 16, "R4 reply");
        // R8 reserved address
        send_frame(16'hB123, 16, "R8");
        send_frame(16'hF000, 16, "R8");
        send_frame(16'h0002, 16, "R8 reply");
        // R7 guarded register 0
        send_frame(16'h8FFF, 16, "R7 locked");
        send_frame(16'h8400, 16, "R7 sleep");
        send_frame(16'h0003, 16, "R7 gap");
        send_frame(16'h8123, 16, "R7 relocked");
        send_frame(16'h8400, 16, "R7 sleep");
        send_frame(16'h8ABC, 16, "R7 unlocked");
        // R12 software reset gating
        send_frame(16'h9555, 16, "R12 blocked");
        send_frame(16'h8400, 16, "R12 sleep");
        send_frame(16'h8000, 16, "R12 bit11 only");
        send_frame(16'h8400, 16, "R12 sleep");
        send_frame(16'h8FFF, 16, "R12 set again");
        pulse_chip_reset();
        chk("R12 swrst cleared", {20'd0, ctl_reg0}, {20'd0, m_regs[0]});
        send_frame(16'h9555, 16, "R12 writes resume");
        send_frame(16'h0004, 16, "R12 reply");
        // R9 companded 16-bit
        compand = 1'b1; tx_audio = 16'h12AB;
        send_frame(16'h00C7, 16, "R9");
        tx_audio = 16'h0F3E; send_frame(16'h0081, 16, "R9");
        // R10 8-bit mode, top bit set is still audio
        wide_mode = 1'b0; compand = 1'b0; tx_audio = 16'h00E4;
        send_frame(16'h009B, 8, "R10");
        tx_audio = 16'h0017; send_frame(16'h005A, 8, "R10");
        // R11 short frame then a full one
        wide_mode = 1'b1;
        send_frame(16'h9FFF, 10, "R11 short");
        tx_audio = 16'h6C6C; send_frame(16'h0246, 16, "R11 full");
        repeat (4) @(negedge clk);
        chk("R2 R11 strobe count", strobes_seen, m_strobes);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule